// File: doc/BRIEF.md
# Voltage Monitor Sample Scaler

This block turns a raw count from a voltage monitor into a signed voltage code. Only the low count field of each incoming sample word is used. The block applies a fixed affine map: it multiplies the count by 90 and subtracts 245805. It then doubles the difference when the sample's channel is marked for double scaling, and divides by 1024. The divide rounds toward zero, so a small negative difference yields zero rather than minus one.

Samples enter on a valid/ready handshake. Each sample carries the word and a one-bit scale select. Results leave two cycles later with a valid flag. The pipeline accepts one sample per cycle while ready is high, and ready stays high at all times outside reset. The output value holds its last result until the next result arrives.

Top module: `volt_code_scaler`

## Requirements
- R1: Only bits [15:0] of `inSample` affect the result; bits [31:16] are ignored.
- R2: With `inPreSel` = 0, the result equals (90*n - 245805) / 1024, where n is the 16-bit count.
- R3: With `inPreSel` = 1, the difference (90*n - 245805) is doubled before the divide.
- R4: The divide by 1024 truncates toward zero for negative dividends. For example, n = 0 gives -240, and n = 2731 gives 0.
- R5: A sample accepted at a clock edge shows up with `outValid` high exactly two edges later. Back-to-back samples give back-to-back results, in order.
- R6: While `rst` is high, `outValid` and `inReady` are 0. From the first edge after `rst` falls, `inReady` is 1.
- R7: While `outValid` is low, `outValue` keeps the last result produced.
- R8: The largest input (n = 65535, `inPreSel` = 1) gives 11039 without overflow, and the smallest (n = 0, `inPreSel` = 1) gives -480.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample present |
| inReady | output | 1 | Block accepts a sample this cycle |
| inSample | input | 32 | Sample word; the low 16 bits are the count |
| inPreSel | input | 1 | 0: scale by 1, 1: scale by 2 |
| outValid | output | 1 | Result present this cycle |
| outValue | output | 16 | Signed voltage code |

## Verification
The assertions assume that `inValid` and `inPreSel` are known at every sampled edge and that `rst` is held for at least two edges at start-up. Under those assumptions, the stage-one bound and the two-cycle valid relation follow directly. The bench drives inputs only on falling edges and never leaves `inPreSel` or `inSample` unknown while `inValid` is high. Its counts cover the full 16-bit range, including both ends and the region around the sign change of the difference, so every dividend the stimulus produces lies inside the asserted stage-one range.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadA;  // capture scaled difference
    logic loadB;  // capture divided result
  } stageStrobe_t;
endpackage

// File: rtl/vcs_ctrl.sv
module vcs_ctrl
  import vcs_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  output stageStrobe_t strobes,
  output logic         outValid
);
  logic readyQ;
  logic vld1Q;
  logic vld2Q;
  logic take;

  assign take = inValid && readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ <= 1'b0;
      vld1Q  <= 1'b0;
      vld2Q  <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      vld1Q  <= take;
      vld2Q  <= vld1Q;
    end
  end

  assign inReady        = readyQ;
  assign strobes.loadA  = take;
  assign strobes.loadB  = vld1Q;
  assign outValid       = vld2Q;

  // R5
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> ##1 outValid);

  // R6
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!inReady && !outValid));
endmodule

// File: rtl/vcs_datapath.sv
module vcs_datapath
  import vcs_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int GAIN    = 90,
  parameter int OFFSET  = 245805,
  parameter int FRAC_SH = 10,
  parameter int ACC_W   = 26,
  parameter int RES_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stageStrobe_t            strobes,
  input  logic [CNT_W-1:0]        count,
  input  logic                    preSel,
  output logic signed [RES_W-1:0] result
);
  localparam logic signed [ACC_W-1:0] GAIN_S   = ACC_W'(GAIN);
  localparam logic signed [ACC_W-1:0] OFFSET_S = ACC_W'(OFFSET);
  localparam logic signed [ACC_W-1:0] BIAS_S   = ACC_W'((1 << FRAC_SH) - 1);
  localparam longint ACC_MAX = 2 * ((longint'(1) << CNT_W) - 1) * GAIN - 2 * OFFSET;
  localparam longint ACC_MIN = -2 * longint'(OFFSET);

  logic signed [ACC_W-1:0] cntExt;
  logic signed [ACC_W-1:0] prod;
  logic signed [ACC_W-1:0] diff;
  logic signed [ACC_W-1:0] scaled;
  logic signed [ACC_W-1:0] accQ;
  logic signed [ACC_W-1:0] biased;
  logic signed [RES_W-1:0] resNext;
  logic signed [RES_W-1:0] resQ;

  // Stage one: affine map and pre-scale
  always_comb begin
    cntExt = $signed({{(ACC_W-CNT_W){1'b0}}, count});
    prod   = cntExt * GAIN_S;
    diff   = prod - OFFSET_S;
    scaled = preSel ? (diff <<< 1) : diff;
  end

  always_ff @(posedge clk) begin
    if (rst)                accQ <= '0;
    else if (strobes.loadA) accQ <= scaled;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadA |=> (longint'(accQ) <= ACC_MAX && longint'(accQ) >= ACC_MIN));

  // Stage two: divide rounding toward zero
  always_comb begin
    biased  = accQ[ACC_W-1] ? (accQ + BIAS_S) : accQ;
    resNext = RES_W'(biased >>> FRAC_SH);
  end

  always_ff @(posedge clk) begin
    if (rst)                resQ <= '0;
    else if (strobes.loadB) resQ <= resNext;
  end

  // R4
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadB && !accQ[ACC_W-1]) |=> (resQ >= 0));

  // R7
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadB |=> $stable(resQ));

  assign result = resQ;
endmodule

// File: rtl/volt_code_scaler.sv
module volt_code_scaler
  import vcs_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = 16,
  parameter int GAIN     = 90,
  parameter int OFFSET   = 245805,
  parameter int FRAC_SH  = 10,
  parameter int ACC_W    = 26,
  parameter int RES_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [SAMPLE_W-1:0]     inSample,
  input  logic                    inPreSel,
  output logic                    outValid,
  output logic signed [RES_W-1:0] outValue
);
  stageStrobe_t strobes;
  logic [CNT_W-1:0] count;
  logic unusedHiBits;

  assign count        = inSample[CNT_W-1:0];
  assign unusedHiBits = ^inSample[SAMPLE_W-1:CNT_W];

  vcs_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .strobes  (strobes),
    .outValid (outValid)
  );

  vcs_datapath #(
    .CNT_W   (CNT_W),
    .GAIN    (GAIN),
    .OFFSET  (OFFSET),
    .FRAC_SH (FRAC_SH),
    .ACC_W   (ACC_W),
    .RES_W   (RES_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .count   (count),
    .preSel  (inPreSel),
    .result  (outValue)
  );
endmodule

// File: tb/tb_volt_code_scaler.sv
module tb_volt_code_scaler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inSample = '0;
  logic        inPreSel = 1'b0;
  logic        outValid;
  logic signed [15:0] outValue;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int expQ[$];
  int dueQ[$];
  string tagQ[$];
  int lastExp = 0;
  bit haveLast = 0;

  always #4 clk = ~clk;

  volt_code_scaler dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inSample(inSample), .inPreSel(inPreSel),
    .outValid(outValid), .outValue(outValue)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(int n, bit p);
    int d;
    d = 90 * n - 245805;
    if (p) d = d * 2;
    return d / 1024;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one sample on a falling edge and leave inputs for the next edge
  task automatic send(logic [31:0] word, bit p, string tag);
    @(negedge clk);
    inValid  = 1'b1;
    inSample = word;
    inPreSel = p;
    expQ.push_back(model(int'(word[15:0]), p));
    dueQ.push_back(cyc + 2);
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid  = 1'b0;
      inSample = 32'hDEAD_BEEF;
      inPreSel = 1'b1;
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check("R5 unexpected result", 1, 0);
        end else begin
          automatic int e = expQ.pop_front();
          automatic int d = dueQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(t, int'(outValue), e);
          check("R5 latency", cyc, d);
          lastExp = e;
          haveLast = 1;
        end
      end else if (haveLast) begin
        check("R7 hold", int'(outValue), lastExp);
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 ready in reset", int'(inReady), 0);
    check("R6 valid in reset", int'(outValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 ready after reset", int'(inReady), 1);

    send(32'd0, 0, "R4 n=0 x1");
    send(32'd2731, 0, "R4 n=2731 small negative");
    send(32'd2732, 0, "R2 n=2732");
    send(32'd2744, 0, "R2 n=2744");
    send(32'd40000, 0, "R2 n=40000");
    idle(3);
    send(32'd1000, 1, "R3 n=1000 x2");
    send(32'd30000, 1, "R3 n=30000 x2");
    send(32'd65535, 1, "R8 max x2");
    send(32'd0, 1, "R8 min x2");
    send(32'd65535, 0, "R2 max x1");
    idle(4);
    send(32'hFFFF_1234, 0, "R1 high bits set");
    send(32'h0000_1234, 0, "R1 high bits clear");
    send(32'hA5A5_0000, 1, "R1 high bits n=0");
    idle(2);
    for (int i = 0; i < 40; i++) begin
      automatic logic [31:0] w = 32'(i * 1637 + 2700) ^ (32'(i) << 20);
      send(w, i[0], "R5 stream");
    end
    idle(6);
    check("R5 queue drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule